// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Controller

This block decides when a FIFO-mode serial transmitter raises its "holding register empty" interrupt. It watches the fill count of the 16-entry transmit FIFO, the host's writes into that FIFO and the host's reads of the interrupt identification register. From these it drives one interrupt request line and the identification code for this source. The interrupt only runs while both the FIFO-mode enable and the transmit interrupt enable are set.

When the FIFO runs dry after it has held two or more bytes at the same time, the interrupt is raised at once. When the FIFO has been fed only one byte at a time since the previous empty event, the interrupt is held back. The hold-off lasts one character time minus the stop-bit time, counted in 16x baud ticks. This way a host that trickles single bytes into the FIFO is not interrupted after every byte. A write during the hold-off cancels the pending interrupt.

The surrounding UART supplies a flag that says a receive source of higher priority is pending. In that case the identification code shows "none" for this source, and an identification read leaves this source's request in place.

Top module: `txe_irq_unit`

## Requirements
- R1: `tx_irq` can be 1 only while both `fifo_en` and `tx_ie` are 1. If either is 0 at a clock edge, `tx_irq` is 0 after that edge, and a FIFO that empties while disabled raises no request.
- R2: Suppose the FIFO has held a count of 2 or more since the last empty event. When `fifo_count` then drops to 0, `tx_irq` is 1 right after the clock edge that first samples the count of 0.
- R3: A clock edge with `thr_wr` = 1 leaves `tx_irq` at 0 after it. A write during the hold-off cancels the hold-off, so no request follows from it.
- R4: An edge with `iir_rd` = 1, `tx_irq` = 1 and `rx_pend` = 0 clears `tx_irq`. With `rx_pend` = 1 the read has no effect on `tx_irq`.
- R5: Suppose the FIFO has never held 2 or more bytes since the last empty event. When it then empties, `tx_irq` stays 0 until (`frame_bits` − `stop_bits`) × 16 ticks of `baud_tick` have been sampled, counted from the edges after the one that sees the count of 0. It becomes 1 right after the edge that samples the last of those ticks.
- R6: `tx_id` is 4'b0010 while `tx_irq` = 1 and `rx_pend` = 0. Otherwise it is 4'b0001.
- R7: When the enable (`fifo_en` & `tx_ie`) goes from 0 to 1 while `fifo_count` is 0, `tx_irq` is 1 right after that edge.
- R8: Each empty event clears the "two or more bytes seen" flag. A later empty event after only single-byte occupancy is therefore delayed again as in R5.
- R9: After reset `tx_irq` is 0 and `tx_id` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| fifo_count | input | 5 | Current transmit FIFO fill (0..16) |
| thr_wr | input | 1 | Host write strobe into the transmit FIFO |
| iir_rd | input | 1 | Host read strobe of the identification register |
| rx_pend | input | 1 | A higher-priority receive source is pending |
| baud_tick | input | 1 | 16x baud rate tick, one cycle wide |
| frame_bits | input | 4 | Bits per character including start, parity and stop |
| stop_bits | input | 2 | Number of stop bits (1 or 2) |
| tx_irq | output | 1 | Interrupt request of this source |
| tx_id | output | 4 | Identification code for this source |

## Verification
The bench builds the block with its default parameters: a 16-entry FIFO, 16 ticks per bit and a 4-bit frame length field. With these values the hold-off is at most 240 ticks. That makes it feasible to sweep every frame length from 7 to 12 bits against both stop-bit settings. For each pair the bench checks the tick just before the expected count and the tick that reaches it, and it varies the tick spacing between pairs. The remaining checks walk the empty-event orderings: double occupancy before single occupancy, a write that cancels the hold-off, reads with and without a receive source pending, and the enable edges.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam logic [3:0] ID_THRE = 4'b0010;
  localparam logic [3:0] ID_NONE = 4'b0001;
endpackage

// File: rtl/txe_fill_track.sv
module txe_fill_track #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             thre,
  output logic             empty_rise,
  output logic             seen2
);
  logic thre_q;

  assign thre       = (fifo_count == '0);
  assign empty_rise = thre & ~thre_q;

  // Reset treats the FIFO as already empty, so no spurious empty edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      thre_q <= 1'b1;
      seen2  <= 1'b0;
    end else begin
      thre_q <= thre;
      if (empty_rise)
        seen2 <= 1'b0;
      else if (fifo_count >= CNT_W'(2))
        seen2 <= 1'b1;
    end
  end

  p_seen_clear_r8: assert property (@(posedge clk) disable iff (rst)
    empty_rise |=> !seen2);
endmodule

// File: rtl/txe_char_delay.sv
module txe_char_delay #(
  parameter int FRAME_W = 4,
  parameter int STOP_W  = 2,
  parameter int OVS     = 16,
  localparam int DLY_W  = $clog2(((1 << FRAME_W) - 1) * OVS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               cancel,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [STOP_W-1:0]  stop_bits,
  output logic               zero_load,
  output logic               fire,
  output logic               busy
);
  logic [DLY_W-1:0] load_val;
  logic [DLY_W-1:0] cnt;

  always_comb begin
    if (int'(frame_bits) > int'(stop_bits))
      load_val = DLY_W'((int'(frame_bits) - int'(stop_bits)) * OVS);
    else
      load_val = '0;
  end

  assign zero_load = (load_val == '0);
  assign fire      = busy & tick & ~cancel & (cnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (busy && tick) begin
      cnt <= cnt - DLY_W'(1);
      if (cnt == DLY_W'(1))
        busy <= 1'b0;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !cancel && !start) |=> $stable(cnt));
  p_fire_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && !start) |=> !busy);
  p_cancel_r3: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !busy);
endmodule

// File: rtl/txe_irq_state.sv
module txe_irq_state (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic thre,
  input  logic set_now,
  input  logic fire,
  input  logic thr_wr,
  input  logic clr_rd,
  output logic pend
);
  logic en_q;
  logic en_rise;

  assign en_rise = en & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      en_q <= en;
      if (!en || thr_wr)
        pend <= 1'b0;
      else if (set_now || (fire && thre) || (en_rise && thre))
        pend <= 1'b1;
      else if (clr_rd)
        pend <= 1'b0;
    end
  end

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pend);
  p_wr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !pend);
  p_en_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (en_rise && thre && !thr_wr) |=> pend);
endmodule

// File: rtl/txe_irq_unit.sv
module txe_irq_unit #(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 4,
  parameter int STOP_W  = 2,
  parameter int OVS     = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en,
  input  logic               tx_ie,
  input  logic [CNT_W-1:0]   fifo_count,
  input  logic               thr_wr,
  input  logic               iir_rd,
  input  logic               rx_pend,
  input  logic               baud_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [STOP_W-1:0]  stop_bits,
  output logic               tx_irq,
  output logic [3:0]         tx_id
);
  import txe_pkg::*;

  logic en, thre, empty_rise, seen2;
  logic zero_load, fire, busy;
  logic start, set_now, cancel, clr_rd;

  assign en = fifo_en & tx_ie;

  txe_fill_track #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst(rst), .fifo_count(fifo_count),
    .thre(thre), .empty_rise(empty_rise), .seen2(seen2)
  );

  // Dense occupancy (or a degenerate zero-length delay) raises at once;
  // single-byte trickle goes through the character-time hold-off.
  assign set_now = empty_rise & en & (seen2 | zero_load);
  assign start   = empty_rise & en & ~seen2 & ~zero_load & ~thr_wr;
  assign cancel  = thr_wr | ~en;
  assign clr_rd  = iir_rd & tx_irq & ~rx_pend;

  txe_char_delay #(.FRAME_W(FRAME_W), .STOP_W(STOP_W), .OVS(OVS)) u_dly (
    .clk(clk), .rst(rst), .start(start), .cancel(cancel), .tick(baud_tick),
    .frame_bits(frame_bits), .stop_bits(stop_bits),
    .zero_load(zero_load), .fire(fire), .busy(busy)
  );

  txe_irq_state u_state (
    .clk(clk), .rst(rst), .en(en), .thre(thre), .set_now(set_now),
    .fire(fire), .thr_wr(thr_wr), .clr_rd(clr_rd), .pend(tx_irq)
  );

  assign tx_id = (tx_irq && !rx_pend) ? ID_THRE : ID_NONE;

  p_id_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !rx_pend) |-> (tx_id == ID_THRE));
  p_rd_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && rx_pend && en && !thr_wr) |=> tx_irq);
  p_no_early_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_irq && !fire && !set_now && en && !thr_wr &&
     !(iir_rd && rx_pend)) |=> !tx_irq || $past(thre && !$past(en)));
endmodule

// File: tb/txe_irq_unit_test.sv
module txe_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, tx_ie = 1'b0;
  logic [4:0] fifo_count = '0;
  logic       thr_wr = 1'b0, iir_rd = 1'b0, rx_pend = 1'b0, baud_tick = 1'b0;
  logic [3:0] frame_bits = 4'd10;
  logic [1:0] stop_bits = 2'd1;
  logic       tx_irq;
  logic [3:0] tx_id;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  txe_irq_unit uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_ie(tx_ie),
    .fifo_count(fifo_count), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .rx_pend(rx_pend), .baud_tick(baud_tick), .frame_bits(frame_bits),
    .stop_bits(stop_bits), .tx_irq(tx_irq), .tx_id(tx_id)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 1; g < gap; g++) step();
      baud_tick = 1'b1;
      step();
      baud_tick = 1'b0;
    end
  endtask

  task automatic wr_and_fill(int peak);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    fifo_count = 5'(peak); step();
    fifo_count = 5'd1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R9 irq", {3'b0, tx_irq}, 4'h0);
    chk("R9 id", tx_id, 4'h1);
    rst = 1'b0;
    step();

    // R1: disabled, dense empty raises nothing
    fifo_en = 1'b1;
    wr_and_fill(3);
    fifo_count = 0; step();
    chk("R1 disabled", {3'b0, tx_irq}, 4'h0);

    // R7: enable rising while empty
    tx_ie = 1'b1; step();
    chk("R7 enable rise", {3'b0, tx_irq}, 4'h1);
    chk("R6 id thre", tx_id, 4'h2);

    // R1: drop FIFO enable
    fifo_en = 1'b0; step();
    chk("R1 fifo_en low", {3'b0, tx_irq}, 4'h0);
    fifo_en = 1'b1; step();
    chk("R7 fifo_en rise", {3'b0, tx_irq}, 4'h1);

    // R4: read blocked by receive source, then effective
    rx_pend = 1'b1; step();
    chk("R6 id none", tx_id, 4'h1);
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
    chk("R4 read blocked", {3'b0, tx_irq}, 4'h1);
    rx_pend = 1'b0;
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
    chk("R4 read clears", {3'b0, tx_irq}, 4'h0);
    chk("R6 id after clear", tx_id, 4'h1);

    // R2: dense occupancy then empty is immediate
    wr_and_fill(2);
    chk("R3 write cleared", {3'b0, tx_irq}, 4'h0);
    fifo_count = 0; step();
    chk("R2 immediate", {3'b0, tx_irq}, 4'h1);

    // R3: plain write clears
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    chk("R3 write clears", {3'b0, tx_irq}, 4'h0);

    // R8: single occupancy after that is delayed again
    fifo_count = 5'd1; step();
    fifo_count = 0; step();
    chk("R8 delayed again", {3'b0, tx_irq}, 4'h0);
    ticks(10, 1);
    chk("R8 still waiting", {3'b0, tx_irq}, 4'h0);

    // R3: write during hold-off cancels it
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    fifo_count = 5'd1;
    ticks(200, 1);
    chk("R3 cancel", {3'b0, tx_irq}, 4'h0);
    fifo_count = 0; step();

    // R5: sweep frame lengths and stop settings
    for (int fb = 7; fb <= 12; fb++) begin
      for (int sb = 1; sb <= 2; sb++) begin
        int load;
        int gap;
        load = (fb - sb) * 16;
        gap = 1 + (fb % 3);
        frame_bits = 4'(fb);
        stop_bits = 2'(sb);
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        fifo_count = 5'd1; step();
        fifo_count = 0; step();
        ticks(load - 1, gap);
        chk($sformatf("R5 before f%0d s%0d", fb, sb), {3'b0, tx_irq}, 4'h0);
        ticks(1, gap);
        chk($sformatf("R5 at f%0d s%0d", fb, sb), {3'b0, tx_irq}, 4'h1);
      end
    end

    // R1: disable during hold-off
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    fifo_count = 5'd1; step();
    fifo_count = 0; step();
    tx_ie = 1'b0; step();
    tx_ie = 1'b1; step();
    chk("R1/R7 reenable", {3'b0, tx_irq}, 4'h1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule